// File: doc/BRIEF.md
# Frequency-Hopping Slot and Channel Controller

This block is the slot-timing core of the master node in a small frequency-hopping network. A tick counter divides the system clock into fixed slots, and a slot counter numbers them. Each slot carries a radio channel index between 0 and 78; the carrier frequency is 2402 + index MHz. The index comes from a scrambler seeded by the master's 48-bit device address, so the address fixes both the hop order and its starting point.

The host raises `txReq` for one cycle with a packet length and a 3-bit destination member address. The controller accepts the request only when idle and with a legal length. A master packet may begin only at the start of an even-numbered slot, so an accepted request waits for the next such boundary. The packet keeps one channel for all of its slots. The following slot is reserved for the slave's answer. After that the channel again follows the sequence for the current slot number, so the channels of the slots the packet covered are skipped, not postponed.

Top module: `fhSlotController`

## Requirements
- R1: `chanIdx` is always below 79. Outside a master packet it equals H(current slot). H(n) is computed as follows. Let e = (n[7:0] + P) mod 256, with P = addr[23:16] ^ addr[31:24]. Let x = (addr[15:0] ^ addr[47:32]) ^ {e, e}; if x is 0, use 16'hACE1. Then shift x left 8 times, feeding in x[15]^x[13]^x[12]^x[10] as bit 0 each time. H(n) = x mod 79.
- R2: `slotIdx` starts at 0 after reset and increases by one every `SLOT_TICKS` clock cycles, counted from the first edge after reset is released.
- R3: `txPhase` rises only at the first cycle of a slot whose number is even.
- R4: A master packet lasts exactly `txLen` slots. During all of them `chanIdx` equals H(start slot).
- R5: The slot right after a master packet is a receive slot: `txPhase` is 0, `busy` is 1, and `chanIdx` equals H(that slot).
- R6: From the slot after the receive slot onward, `busy` is 0 and `chanIdx` equals H(current slot).
- R7: While idle, a request with `txLen` other than 1, 3 or 5 is not accepted. `lenErr` is 1 for exactly the one cycle after it, and `busy` stays 0.
- R8: An accepted request sets `busy` in the next cycle. The packet starts at the first slot boundary after acceptance whose new slot number is even.
- R9: While `busy` is 1, requests are ignored: no `lenErr`, and no further packet after the current exchange.
- R10: During a master packet, `destOut` shows the accepted destination and `bcast` is 1 exactly when that destination is 0. Both are 0 outside a packet.
- R11: During reset, `slotIdx`, `txPhase`, `busy`, `bcast` and `lenErr` are 0 and `chanIdx` equals H(0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterAddr | input | 48 | Master device address; seeds the hop sequence and its phase |
| txReq | input | 1 | One-cycle request to send a packet |
| txLen | input | 3 | Requested packet length in slots |
| destAddr | input | 3 | Destination member address; 0 addresses all members |
| slotIdx | output | SLOT_W | Current slot number |
| chanIdx | output | 7 | Channel index for the current slot |
| txPhase | output | 1 | 1 in master transmit slots, 0 otherwise |
| busy | output | 1 | Request pending, packet running or reply slot in progress |
| bcast | output | 1 | Current master packet is a broadcast |
| destOut | output | 3 | Destination of the current master packet |
| lenErr | output | 1 | One-cycle flag for a rejected packet length |

## Verification
A request sampled at edge k shows up on `busy` or `lenErr` right after that edge. Slot n begins at edge n·SLOT_TICKS, and `slotIdx`, `txPhase` and `chanIdx` take their new values at that edge. The bench counts edges from reset release and derives the start slot as the smallest even n with n·SLOT_TICKS > k. It samples one cycle before the start, exactly at the start, and mid-slot for each later slot. Every sample is taken 1 ns after a rising edge, so each check sees the value that edge produced.

// File: rtl/fhPkg.sv
package fhPkg;
  localparam int ADDR_W   = 48;
  localparam int NUM_CHAN = 79;
  localparam int CHAN_W   = $clog2(NUM_CHAN);

  typedef struct packed {
    logic startPkt;
  } ctrlStrobe_t;

  typedef struct packed {
    logic slotEdge;
    logic nextEven;
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MTX  = 2'd2,
    ST_SRX  = 2'd3
  } ctrlState_t;
endpackage

// File: rtl/fhHopGen.sv
module fhHopGen
  import fhPkg::*;
#(
  parameter int HOP_STEPS = 8
) (
  input  logic [15:0]       seedWord,
  input  logic [7:0]        phaseOff,
  input  logic [7:0]        slotLow,
  output logic [CHAN_W-1:0] chan
);
  logic [7:0]  effSlot;
  logic [15:0] mixState;

  always_comb begin
    effSlot  = slotLow + phaseOff;
    mixState = seedWord ^ {effSlot, effSlot};
    if (mixState == 16'h0000) mixState = 16'hACE1;
    for (int i = 0; i < HOP_STEPS; i++) begin
      mixState = {mixState[14:0],
                  mixState[15] ^ mixState[13] ^ mixState[12] ^ mixState[10]};
    end
    chan = CHAN_W'(mixState % 16'(NUM_CHAN));
  end
endmodule

// File: rtl/fhDatapath.sv
module fhDatapath
  import fhPkg::*;
#(
  parameter int SLOT_TICKS = 31250,
  parameter int SLOT_W     = 8,
  parameter int HOP_STEPS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] masterAddr,
  input  ctrlStrobe_t       strobe,
  input  logic              inTx,
  output dpStatus_t         status,
  output logic [SLOT_W-1:0] slotCnt,
  output logic [CHAN_W-1:0] chanIdx
);
  localparam int TICK_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_TICKS - 1);

  logic [TICK_W-1:0] tickCnt;
  logic [SLOT_W-1:0] startSlot;
  logic [SLOT_W-1:0] hopSlot;
  logic [15:0]       seedWord;
  logic [7:0]        phaseOff;
  logic              slotEdge;

  assign slotEdge = (tickCnt == TICK_LAST);
  assign status.slotEdge = slotEdge;
  assign status.nextEven = slotCnt[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      slotCnt <= '0;
    end else if (slotEdge) begin
      tickCnt <= '0;
      slotCnt <= slotCnt + 1'b1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startSlot <= '0;
    else if (strobe.startPkt) startSlot <= slotCnt + 1'b1;
  end

  assign seedWord = masterAddr[15:0] ^ masterAddr[47:32];
  assign phaseOff = masterAddr[23:16] ^ masterAddr[31:24];
  assign hopSlot  = inTx ? startSlot : slotCnt;

  fhHopGen #(.HOP_STEPS(HOP_STEPS)) i_hop (
    .seedWord(seedWord),
    .phaseOff(phaseOff),
    .slotLow (8'(hopSlot)),
    .chan    (chanIdx)
  );

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    slotEdge |=> slotCnt == SLOT_W'($past(slotCnt) + 1'b1));

  assert_start_even_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startPkt |=> (slotCnt[0] == 1'b0) && (startSlot == slotCnt));
endmodule

// File: rtl/fhControl.sv
module fhControl
  import fhPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txReq,
  input  logic [2:0]  txLen,
  input  logic [2:0]  destAddr,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        inTx,
  output logic        busy,
  output logic        bcast,
  output logic [2:0]  destOut,
  output logic        lenErr
);
  ctrlState_t state;
  logic [2:0] remaining;
  logic [2:0] lenReg;
  logic [2:0] destReg;
  logic       lenOk;

  assign lenOk = (txLen == 3'd1) || (txLen == 3'd3) || (txLen == 3'd5);
  assign strobe.startPkt = (state == ST_WAIT) && status.slotEdge && status.nextEven;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      lenReg    <= '0;
      destReg   <= '0;
      lenErr    <= 1'b0;
    end else begin
      lenErr <= (state == ST_IDLE) && txReq && !lenOk;
      unique case (state)
        ST_IDLE: if (txReq && lenOk) begin
          state   <= ST_WAIT;
          lenReg  <= txLen;
          destReg <= destAddr;
        end
        ST_WAIT: if (strobe.startPkt) begin
          state     <= ST_MTX;
          remaining <= lenReg - 3'd1;
        end
        ST_MTX: if (status.slotEdge) begin
          if (remaining == 3'd0) state <= ST_SRX;
          else remaining <= remaining - 3'd1;
        end
        ST_SRX: if (status.slotEdge) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inTx    = (state == ST_MTX);
  assign busy    = (state != ST_IDLE);
  assign bcast   = inTx && (destReg == 3'd0);
  assign destOut = inTx ? destReg : 3'd0;

  assert_lenerr_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> !busy);

  assert_lenerr_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |=> !lenErr);

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txReq) |=> !lenErr);
endmodule

// File: rtl/fhSlotController.sv
module fhSlotController
  import fhPkg::*;
#(
  parameter int SLOT_TICKS = 31250,
  parameter int SLOT_W     = 8,
  parameter int HOP_STEPS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [47:0]       masterAddr,
  input  logic              txReq,
  input  logic [2:0]        txLen,
  input  logic [2:0]        destAddr,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [6:0]        chanIdx,
  output logic              txPhase,
  output logic              busy,
  output logic              bcast,
  output logic [2:0]        destOut,
  output logic              lenErr
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  fhControl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .txReq   (txReq),
    .txLen   (txLen),
    .destAddr(destAddr),
    .status  (status),
    .strobe  (strobe),
    .inTx    (txPhase),
    .busy    (busy),
    .bcast   (bcast),
    .destOut (destOut),
    .lenErr  (lenErr)
  );

  fhDatapath #(
    .SLOT_TICKS(SLOT_TICKS),
    .SLOT_W    (SLOT_W),
    .HOP_STEPS (HOP_STEPS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .masterAddr(masterAddr),
    .strobe    (strobe),
    .inTx      (txPhase),
    .status    (status),
    .slotCnt   (slotIdx),
    .chanIdx   (chanIdx)
  );

  assert_chan_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    chanIdx < 7'd79);

  assert_rise_even_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPhase) |-> (slotIdx[0] == 1'b0));

  assert_chan_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase && $past(txPhase)) |-> $stable(chanIdx));

  assert_reply_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txPhase) |-> (busy && slotIdx[0]));

  assert_bcast_tx_R10: assert property (@(posedge clk) disable iff (!rstN)
    bcast |-> (txPhase && destOut == 3'd0));
endmodule

// File: tb/test_fhSlotController.sv
module test_fhSlotController;
  localparam int TICKS = 8;
  localparam logic [47:0] ADDR = 48'h1234_5678_9ABC;
  // vector: {gap[7:0], len[2:0], dest[2:0]}
  localparam logic [13:0] VEC [0:6] = '{
    {8'd2,  3'd1, 3'd1},
    {8'd5,  3'd3, 3'd0},
    {8'd9,  3'd5, 3'd4},
    {8'd3,  3'd2, 3'd3},
    {8'd11, 3'd3, 3'd7},
    {8'd4,  3'd0, 3'd2},
    {8'd1,  3'd5, 3'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txReq = 1'b0;
  logic [2:0] txLen = 3'd0;
  logic [2:0] destAddr = 3'd0;
  logic [7:0] slotIdx;
  logic [6:0] chanIdx;
  logic txPhase, busy, bcast, lenErr;
  logic [2:0] destOut;

  int cyc = 0;
  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fhSlotController #(.SLOT_TICKS(TICKS)) i_fhSlotController (
    .clk(clk), .rstN(rstN), .masterAddr(ADDR), .txReq(txReq),
    .txLen(txLen), .destAddr(destAddr), .slotIdx(slotIdx),
    .chanIdx(chanIdx), .txPhase(txPhase), .busy(busy), .bcast(bcast),
    .destOut(destOut), .lenErr(lenErr)
  );

  function automatic int hopRef(int slot);
    logic [7:0]  e;
    logic [15:0] x;
    e = 8'(slot) + (ADDR[23:16] ^ ADDR[31:24]);
    x = (ADDR[15:0] ^ ADDR[47:32]) ^ {e, e};
    if (x == 16'h0) x = 16'hACE1;
    for (int i = 0; i < 8; i++) x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    return int'(x % 16'd79);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk); #1; cyc++;
  endtask

  task automatic stepTo(input int target);
    while (cyc < target) step();
  endtask

  task automatic pulseReq(input logic [2:0] len, input logic [2:0] dest);
    txReq = 1'b1; txLen = len; destAddr = dest;
    step();
    txReq = 1'b0;
  endtask

  // run one accepted packet and its reply slot; k is the accepting edge
  task automatic followPacket(input int k, input int len, input int dest);
    int s;
    s = k / TICKS + 1;
    if (s % 2 != 0) s++;
    check("R8 busy after accept", int'(busy), 1);
    check("R8 no tx before even slot", int'(txPhase), 0);
    stepTo(TICKS * s - 1);
    check("R8 still waiting", int'(txPhase), 0);
    stepTo(TICKS * s);
    check("R3 start at even slot", int'(txPhase), 1);
    check("R3 start slot number", int'(slotIdx), s);
    check("R4 channel at start", int'(chanIdx), hopRef(s));
    check("R10 destination", int'(destOut), dest);
    check("R10 broadcast flag", int'(bcast), int'(dest == 0));
    for (int t = s + 1; t < s + len; t++) begin
      stepTo(TICKS * t + 4);
      check("R4 channel held", int'(chanIdx), hopRef(s));
      check("R4 still transmitting", int'(txPhase), 1);
    end
    stepTo(TICKS * (s + len) + 2);
    check("R5 reply slot rx", int'(txPhase), 0);
    check("R5 reply slot busy", int'(busy), 1);
    check("R5 reply channel", int'(chanIdx), hopRef(s + len));
    check("R10 bcast off in rx", int'(bcast), 0);
    stepTo(TICKS * (s + len + 1) + 1);
    check("R6 idle after reply", int'(busy), 0);
    check("R6 channel skips ahead", int'(chanIdx), hopRef(s + len + 1));
    check("R2 slot count", int'(slotIdx), s + len + 1);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset slot", int'(slotIdx), 0);
    check("R11 reset txPhase", int'(txPhase), 0);
    check("R11 reset busy", int'(busy), 0);
    check("R11 reset lenErr", int'(lenErr), 0);
    check("R11 reset bcast", int'(bcast), 0);
    check("R11 reset channel R1", int'(chanIdx), hopRef(0));
    rstN = 1'b1;
    cyc = 0;
    stepTo(TICKS * 3 + 2);
    check("R2 slot after three periods", int'(slotIdx), 3);
    check("R1 idle channel", int'(chanIdx), hopRef(3));

    foreach (VEC[i]) begin
      int gap, len, dest, k;
      gap = int'(VEC[i][13:6]); len = int'(VEC[i][5:3]); dest = int'(VEC[i][2:0]);
      repeat (gap) step();
      pulseReq(3'(len), 3'(dest));
      k = cyc;
      if (len == 1 || len == 3 || len == 5) begin
        followPacket(k, len, dest);
      end else begin
        check("R7 lenErr set", int'(lenErr), 1);
        check("R7 not busy", int'(busy), 0);
        step();
        check("R7 lenErr one cycle", int'(lenErr), 0);
        check("R7 still idle", int'(busy), 0);
      end
    end

    // R9: requests during busy are dropped
    begin
      int k, s;
      step();
      pulseReq(3'd5, 3'd2);
      k = cyc;
      s = k / TICKS + 1;
      if (s % 2 != 0) s++;
      stepTo(TICKS * s + 2);
      pulseReq(3'd1, 3'd3);
      check("R9 no lenErr", int'(lenErr), 0);
      pulseReq(3'd6, 3'd3);
      check("R9 invalid ignored", int'(lenErr), 0);
      check("R9 destination unchanged", int'(destOut), 2);
      stepTo(TICKS * (s + 4) + 3);
      check("R9 channel kept", int'(chanIdx), hopRef(s));
      stepTo(TICKS * (s + 6) + 1);
      check("R9 idle after reply", int'(busy), 0);
      stepTo(TICKS * (s + 9) + 1);
      check("R9 no extra packet", int'(busy), 0);
      check("R9 no extra tx", int'(txPhase), 0);
      check("R1 channel resumes", int'(chanIdx), hopRef(s + 9));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule